// File: doc/BRIEF.md
# Interrupt Acceptance Gate

This block sits beside a small CPU core and decides, on every clock, whether a pending interrupt may be taken now. It owns the core's interrupt mask state: a global mask bit, a multi-bit mask level and a trace bit. When an interrupt is taken it raises a one-cycle accept strobe that carries the kind of source and the level that was accepted. Taking an interrupt counts as entry into exception handling, so the block sets the global mask bit in the same cycle.

The core sends a write pulse when an operation that modifies the control register completes. A load, AND, OR or XOR of the control register all count as a write. The pulse loads the new mask fields and starts a short hold-off. During the hold-off no interrupt is accepted, and that includes the non-maskable one. A read of the control register is signalled on a separate pulse, and it never starts a hold-off. Vector fetch, stacking and arbitration between several maskable sources belong to other blocks.

Top module: `irq_accept_gate`

## Requirements
- R1: In the cycle after reset is sampled high, the global mask output is 1, the mask level output is all ones (7), the trace output is 0 and the accept strobe is 0. Any hold-off in progress is cleared.
- R2: While the global mask bit is 1, no maskable request is accepted, whatever its level.
- R3: A pending non-maskable request is accepted whatever the value of the global mask bit.
- R4: With the global mask bit at 0, a maskable request is accepted only when its level is strictly greater than the mask level. The one exception is level 7, which is accepted even when the mask level is 7.
- R5: A sampled write pulse blocks every acceptance, including the non-maskable one, in its own cycle and in the next three cycles. A request held pending from the write onward is accepted at the fourth clock edge after the edge that sampled the write.
- R6: A write pulse that arrives while a hold-off is running restarts the hold-off at its full length of three cycles.
- R7: A read pulse starts no hold-off. A non-maskable request presented together with a read pulse is accepted at the next edge.
- R8: At the edge where the accept strobe rises, the global mask bit becomes 1. The mask level and the trace bit do not change.
- R9: The accept strobe lasts exactly one cycle. No acceptance takes place in the cycle that follows a strobe, even when a request stays pending.
- R10: When a non-maskable and a maskable request can both be taken, the non-maskable one wins. The kind output encodes 2'b00 for none, 2'b01 for non-maskable and 2'b10 for maskable. The level output carries the accepted maskable level, and it carries 0 for a non-maskable accept.
- R11: A write pulse loads the global mask, mask level and trace inputs into the state. The new values appear on the state outputs after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control-register write operation completed (load, AND, OR, XOR) |
| ctl_rd | input | 1 | Control-register read operation completed |
| wr_gmask | input | 1 | New global mask bit, used with ctl_wr |
| wr_lvl | input | LVL_W | New mask level, used with ctl_wr |
| wr_trace | input | 1 | New trace bit, used with ctl_wr |
| nmi_pend | input | 1 | Non-maskable request pending |
| irq_pend | input | 1 | Maskable request pending |
| irq_lvl | input | LVL_W | Level of the pending maskable request |
| acc_stb | output | 1 | One-cycle accept strobe |
| acc_kind | output | 2 | Kind of accepted source: 00 none, 01 non-maskable, 10 maskable |
| acc_lvl | output | LVL_W | Accepted maskable level, 0 for a non-maskable accept |
| gmask | output | 1 | Global mask bit |
| mask_lvl | output | LVL_W | Mask level |
| trace | output | 1 | Trace bit |

## Verification
On every cycle, the assertions check the following. A blocked cycle produces no strobe. The strobe never lasts two cycles. A maskable accept only follows a cycle in which the global mask was clear. A free non-maskable request always turns into an accept that names the non-maskable source. A read pulse never delays acceptance. The hold-off counter reloads on a write and counts down by one. Only the directed scenarios show the exact edge at which acceptance resumes after single and back-to-back writes, the strict compare against the mask level including the level-7 exception, and the values left on the state outputs after reset, writes and exception entry.

// File: rtl/igate_pkg.sv
package igate_pkg;
  typedef enum logic [1:0] {
    KIND_NONE     = 2'b00,
    KIND_NMI      = 2'b01,
    KIND_MASKABLE = 2'b10
  } acc_kind_e;
endpackage

// File: rtl/igate_holdoff.sv
module igate_holdoff #(
  parameter int HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= CNT_FULL;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == CNT_FULL)); // R6
  AST_HOLD_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (!load && busy) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
  AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL); // R5
endmodule

// File: rtl/igate_mask_regs.sv
module igate_mask_regs #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             wr_gmask,
  input  logic [LVL_W-1:0] wr_lvl,
  input  logic             wr_trace,
  input  logic             entry,
  output logic             gmask,
  output logic [LVL_W-1:0] mask_lvl,
  output logic             trace
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gmask    <= 1'b1;
      mask_lvl <= '1;
      trace    <= 1'b0;
    end else if (entry) begin
      gmask    <= 1'b1;
    end else if (wr) begin
      gmask    <= wr_gmask;
      mask_lvl <= wr_lvl;
      trace    <= wr_trace;
    end
  end

  AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (rst)
    entry |=> gmask); // R8
  AST_ENTRY_KEEPS_LVL: assert property (@(posedge clk) disable iff (rst)
    entry |=> ($stable(mask_lvl) && $stable(trace))); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (gmask && (mask_lvl == '1) && !trace)); // R1
endmodule

// File: rtl/igate_decide.sv
module igate_decide
  import igate_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blocked,
  input  logic             gmask,
  input  logic [LVL_W-1:0] mask_lvl,
  input  logic             nmi_pend,
  input  logic             irq_pend,
  input  logic [LVL_W-1:0] irq_lvl,
  output logic             take,
  output logic             acc_stb,
  output acc_kind_e        acc_kind,
  output logic [LVL_W-1:0] acc_lvl
);
  localparam logic [LVL_W-1:0] LVL_TOP = '1;

  logic lvl_ok, free, nmi_take, irq_take;

  always_comb begin
    lvl_ok   = (irq_lvl > mask_lvl) || (irq_lvl == LVL_TOP);
    free     = !blocked && !acc_stb;
    nmi_take = free && nmi_pend;
    irq_take = free && irq_pend && !gmask && lvl_ok;
    take     = nmi_take || irq_take;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_stb  <= 1'b0;
      acc_kind <= KIND_NONE;
      acc_lvl  <= '0;
    end else begin
      acc_stb <= take;
      if (nmi_take) begin
        acc_kind <= KIND_NMI;
        acc_lvl  <= '0;
      end else if (irq_take) begin
        acc_kind <= KIND_MASKABLE;
        acc_lvl  <= irq_lvl;
      end else begin
        acc_kind <= KIND_NONE;
        acc_lvl  <= '0;
      end
    end
  end

  AST_BLOCKED_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    blocked |=> !acc_stb); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    acc_stb |=> !acc_stb); // R9
  AST_MASKABLE_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && acc_kind == KIND_MASKABLE) |-> !$past(gmask)); // R2
  AST_NMI_WINS: assert property (@(posedge clk) disable iff (rst)
    (nmi_pend && !blocked && !acc_stb) |=> (acc_stb && acc_kind == KIND_NMI)); // R10
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import igate_pkg::*;
#(
  parameter int LVL_W    = 3,
  parameter int HOLD_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_rd,
  input  logic             wr_gmask,
  input  logic [LVL_W-1:0] wr_lvl,
  input  logic             wr_trace,
  input  logic             nmi_pend,
  input  logic             irq_pend,
  input  logic [LVL_W-1:0] irq_lvl,
  output logic             acc_stb,
  output logic [1:0]       acc_kind,
  output logic [LVL_W-1:0] acc_lvl,
  output logic             gmask,
  output logic [LVL_W-1:0] mask_lvl,
  output logic             trace
);
  logic      busy, blocked, take;
  acc_kind_e kind_w;

  assign blocked  = ctl_wr || busy;
  assign acc_kind = kind_w;

  igate_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .load(ctl_wr), .busy(busy)
  );

  igate_mask_regs #(.LVL_W(LVL_W)) u_mask (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wr_gmask(wr_gmask),
    .wr_lvl(wr_lvl), .wr_trace(wr_trace), .entry(take),
    .gmask(gmask), .mask_lvl(mask_lvl), .trace(trace)
  );

  igate_decide #(.LVL_W(LVL_W)) u_dec (
    .clk(clk), .rst(rst), .blocked(blocked), .gmask(gmask),
    .mask_lvl(mask_lvl), .nmi_pend(nmi_pend), .irq_pend(irq_pend),
    .irq_lvl(irq_lvl), .take(take), .acc_stb(acc_stb),
    .acc_kind(kind_w), .acc_lvl(acc_lvl)
  );

  AST_READ_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctl_rd && !ctl_wr && !busy && nmi_pend && !acc_stb) |=> acc_stb); // R7
endmodule

// File: tb/irq_accept_gate_tb_top.sv
module irq_accept_gate_tb_top;
  localparam int LVL_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 1'b0, ctl_rd = 1'b0, wr_gmask = 1'b0, wr_trace = 1'b0;
  logic [LVL_W-1:0] wr_lvl = '0, irq_lvl = '0;
  logic nmi_pend = 1'b0, irq_pend = 1'b0;
  logic acc_stb, gmask, trace;
  logic [1:0] acc_kind;
  logic [LVL_W-1:0] acc_lvl, mask_lvl;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_accept_gate #(.LVL_W(LVL_W), .HOLD_CYC(3)) dut_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .wr_gmask(wr_gmask), .wr_lvl(wr_lvl), .wr_trace(wr_trace),
    .nmi_pend(nmi_pend), .irq_pend(irq_pend), .irq_lvl(irq_lvl),
    .acc_stb(acc_stb), .acc_kind(acc_kind), .acc_lvl(acc_lvl),
    .gmask(gmask), .mask_lvl(mask_lvl), .trace(trace)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  task automatic do_write(logic g, logic [LVL_W-1:0] l, logic t);
    @(negedge clk);
    ctl_wr = 1'b1; wr_gmask = g; wr_lvl = l; wr_trace = t;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "gmask", gmask, 1);
    chk("R1", "mask_lvl", mask_lvl, 7);
    chk("R1", "trace", trace, 0);
    chk("R1", "acc_stb", acc_stb, 0);
  endtask

  task automatic t_gmask_blocks();
    irq_pend = 1'b1; irq_lvl = 3'd7;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2", "acc_stb masked", acc_stb, 0);
    end
    irq_pend = 1'b0;
  endtask

  task automatic t_nmi_under_mask();
    nmi_pend = 1'b1;
    @(negedge clk);
    chk("R3", "nmi accepted", acc_stb, 1);
    chk("R3", "kind", acc_kind, 1);
    @(negedge clk);
    chk("R9", "gap after strobe", acc_stb, 0);
    @(negedge clk);
    chk("R9", "re-accept after gap", acc_stb, 1);
    nmi_pend = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_level_compare();
    do_write(1'b0, 3'd3, 1'b0);
    settle();
    chk("R11", "gmask written", gmask, 0);
    chk("R11", "mask_lvl written", mask_lvl, 3);
    irq_pend = 1'b1; irq_lvl = 3'd3;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4", "equal level held off", acc_stb, 0);
    end
    irq_lvl = 3'd4;
    @(negedge clk);
    chk("R4", "higher level accepted", acc_stb, 1);
    chk("R10", "kind maskable", acc_kind, 2);
    chk("R10", "acc_lvl", acc_lvl, 4);
    chk("R8", "gmask set on entry", gmask, 1);
    chk("R8", "mask_lvl kept", mask_lvl, 3);
    chk("R8", "trace kept", trace, 0);
    @(negedge clk);
    chk("R9", "single strobe", acc_stb, 0);
    @(negedge clk);
    chk("R2", "masked after entry", acc_stb, 0);
    irq_pend = 1'b0;
  endtask

  task automatic t_level_top();
    do_write(1'b0, 3'd7, 1'b0);
    settle();
    irq_pend = 1'b1; irq_lvl = 3'd6;
    @(negedge clk);
    chk("R4", "level 6 under mask 7", acc_stb, 0);
    irq_lvl = 3'd7;
    @(negedge clk);
    chk("R4", "level 7 under mask 7", acc_stb, 1);
    chk("R4", "acc_lvl 7", acc_lvl, 7);
    irq_pend = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_holdoff();
    do_write(1'b0, 3'd0, 1'b0);
    nmi_pend = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5", "nmi held off", acc_stb, 0);
    end
    @(negedge clk);
    chk("R5", "nmi after hold-off", acc_stb, 1);
    chk("R5", "kind nmi", acc_kind, 1);
    nmi_pend = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_restart();
    @(negedge clk);
    ctl_wr = 1'b1; wr_gmask = 1'b0; wr_lvl = 3'd0; wr_trace = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ctl_wr = 1'b0;
    nmi_pend = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6", "held after second write", acc_stb, 0);
    end
    @(negedge clk);
    chk("R6", "accept after restart", acc_stb, 1);
    nmi_pend = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_read();
    settle();
    @(negedge clk);
    ctl_rd = 1'b1; nmi_pend = 1'b1;
    @(negedge clk);
    ctl_rd = 1'b0;
    chk("R7", "read starts no hold-off", acc_stb, 1);
    nmi_pend = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_precedence();
    do_write(1'b0, 3'd0, 1'b1);
    settle();
    chk("R11", "trace written", trace, 1);
    nmi_pend = 1'b1; irq_pend = 1'b1; irq_lvl = 3'd5;
    @(negedge clk);
    chk("R10", "both pending strobe", acc_stb, 1);
    chk("R10", "nmi wins", acc_kind, 1);
    chk("R10", "acc_lvl zero for nmi", acc_lvl, 0);
    nmi_pend = 1'b0; irq_pend = 1'b0;
    @(negedge clk);
    chk("R10", "kind none when idle", acc_kind, 0);
  endtask

  initial begin
    t_reset();
    t_gmask_blocks();
    t_nmi_under_mask();
    t_level_compare();
    t_level_top();
    t_holdoff();
    t_restart();
    t_read();
    t_precedence();
    finish_run();
  end
endmodule